// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic stage and status register of a small accumulator-style processor. Each cycle it takes a destination operand and a source operand and produces a 32-bit result for one of four operations: add, subtract, compare, or pass-through. The source operand can be replaced by an 8-bit immediate that is sign-extended to 32 bits. Alongside the result it drives a write-enable that tells the register file whether to store the result. The block is combinational from operands to result.

Four condition flags (carry, zero, sign, overflow) live at fixed positions in a 32-bit status word. The status word is held in a register inside the block. The block also brings out the value that register will take at the next clock edge, so a branch unit can read either the current or the next flags. Compare performs the subtraction only to set the flags and suppresses the writeback. Pass-through, and any cycle without the flag-update enable, leaves the status word unchanged.

Top module: `alu_flags_unit`

## Requirements
- R1: `op_sel_i` selects the operation: 2'b00 add (a + b), 2'b01 subtract (a - b), 2'b10 compare (a - b), 2'b11 pass-through (result = b). `result_o` is combinational from the inputs.
- R2: When `imm_sel_i` is 1, the second operand is `imm8_i` sign-extended from 8 to 32 bits. In that case `b_i` has no effect on the result or the flags.
- R3: The carry flag holds the carry out of bit 31 for add. For subtract and compare it holds the borrow, which is 1 when a < b as unsigned numbers.
- R4: The overflow flag is 1 when the signed result is out of range. For add, this means both operands have the same sign and the result sign differs from it. For subtract and compare, it means the operand signs differ and the result sign differs from a.
- R5: The zero flag is 1 when all 32 result bits are 0. The sign flag equals bit 31 of the result.
- R6: The status word places carry at bit 0, zero at bit 6, sign at bit 7 and overflow at bit 11. Every other bit is 0.
- R7: `wr_en_o` is 0 for compare and 1 for add, subtract and pass-through.
- R8: The status register loads new flags only when `flag_en_i` is 1 and the operation is add, subtract or compare. Otherwise it holds, including pass-through with `flag_en_i` = 1.
- R9: A synchronous active-high `rst_i` clears the status register to 0 at the next clock edge.
- R10: `status_next_o` is the value that `status_o` takes at the next rising edge when reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_sel_i | input | 2 | Operation select (R1 encoding) |
| imm_sel_i | input | 1 | Use the sign-extended immediate as the second operand |
| flag_en_i | input | 1 | Flag update enable |
| a_i | input | 32 | Destination (first) operand |
| b_i | input | 32 | Source (second) operand |
| imm8_i | input | 8 | 8-bit signed immediate |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result writeback enable |
| status_o | output | 32 | Registered status word |
| status_next_o | output | 32 | Status word after the next edge |

## Verification
The operation set is exercised with operand pairs chosen to separate the four flags from one another:
- small positive sums with all flags clear;
- a subtraction that borrows into a negative result (4 - 6);
- sums that overflow into the sign bit, and sums that wrap to zero with a carry;
- the most negative value subtracted from zero and added to itself, which sets several flags at once.

Compare is run with equal operands and with a borrowing pair. This shows that the flags change while the write-enable stays low. Immediates 0xF8, 0x80, 0x7F and 0xFF are used to tell sign extension apart from zero extension, with `b_i` set to an unrelated value. Holding cases cover pass-through with the enable set and subtract with the enable clear.

// File: rtl/alu_flags_pkg.sv
`timescale 1ns/1ps
package alu_flags_pkg;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_CMP  = 2'b10,
    ALU_PASS = 2'b11
  } alu_op_e;

  localparam int unsigned CF_BIT = 0;
  localparam int unsigned ZF_BIT = 6;
  localparam int unsigned SF_BIT = 7;
  localparam int unsigned OF_BIT = 11;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic carry;
  } flags_t;

endpackage

// File: rtl/alu_operand_sel.sv
`timescale 1ns/1ps
module alu_operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  output logic [DATA_W-1:0] opb_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  always_comb begin
    opb_o = imm_sel_i ? sext(imm_i) : b_i;
  end
endmodule

// File: rtl/alu_arith_core.sv
`timescale 1ns/1ps
module alu_arith_core
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  // Adder with carry-in; returns {carry_out, sum}.
  function automatic logic [DATA_W:0] add_c(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y,
                                            input logic              cin);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;

  always_comb begin
    is_sub = (op_i == ALU_SUB) || (op_i == ALU_CMP);
    b_eff  = is_sub ? ~b_i : b_i;
    sum_w  = add_c(a_i, b_eff, is_sub);
    if (op_i == ALU_PASS) begin
      res_o   = b_i;
      carry_o = 1'b0;
      ovf_o   = 1'b0;
    end else begin
      res_o   = sum_w[DATA_W-1:0];
      // subtraction reports borrow = inverted carry out
      carry_o = is_sub ? ~sum_w[DATA_W] : sum_w[DATA_W];
      ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_w[MSB] != a_i[MSB]);
    end
  end
endmodule

// File: rtl/alu_flag_pack.sv
`timescale 1ns/1ps
module alu_flag_pack
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    flags_o.ovf   = ovf_i;
    flags_o.sign  = res_i[DATA_W-1];
    flags_o.zero  = (res_i == '0);
    flags_o.carry = carry_i;
    word_o         = '0;
    word_o[CF_BIT] = flags_o.carry;
    word_o[ZF_BIT] = flags_o.zero;
    word_o[SF_BIT] = flags_o.sign;
    word_o[OF_BIT] = flags_o.ovf;
  end
endmodule

// File: rtl/alu_status_reg.sv
`timescale 1ns/1ps
module alu_status_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] next_o,
  output logic [DATA_W-1:0] q_o
);
  always_comb begin
    next_o = load_i ? d_i : q_o;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= next_o;
  end
endmodule

// File: rtl/alu_flags_unit.sv
`timescale 1ns/1ps
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        op_sel_i,
  input  logic              imm_sel_i,
  input  logic              flag_en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm8_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] status_next_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] flag_word;
  logic              carry_w;
  logic              ovf_w;
  logic              upd_flags;
  flags_t            flags_w;

  assign op        = alu_op_e'(op_sel_i);
  assign wr_en_o   = (op != ALU_CMP);
  assign upd_flags = flag_en_i && (op != ALU_PASS);

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .b_i       (b_i),
    .imm_i     (imm8_i),
    .imm_sel_i (imm_sel_i),
    .opb_o     (opb)
  );

  alu_arith_core #(.DATA_W(DATA_W)) u_core (
    .op_i    (op),
    .a_i     (a_i),
    .b_i     (opb),
    .res_o   (result_o),
    .carry_o (carry_w),
    .ovf_o   (ovf_w)
  );

  alu_flag_pack #(.DATA_W(DATA_W)) u_pack (
    .res_i   (result_o),
    .carry_i (carry_w),
    .ovf_i   (ovf_w),
    .flags_o (flags_w),
    .word_o  (flag_word)
  );

  alu_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (upd_flags),
    .d_i    (flag_word),
    .next_o (status_next_o),
    .q_o    (status_o)
  );
endmodule

// File: rtl/alu_flags_unit_chk.sv
`timescale 1ns/1ps
module alu_flags_unit_chk
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [1:0]        op_sel_i,
  input logic              upd_flags,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] status_next_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << CF_BIT) | (DATA_W'(1) << ZF_BIT) |
    (DATA_W'(1) << SF_BIT) | (DATA_W'(1) << OF_BIT);

  p_pass_copy_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_sel_i == 2'b11) |-> (result_o == opb));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_flags && op_sel_i == 2'b00 && a_i[MSB] != opb[MSB]) |-> !status_next_o[OF_BIT]);

  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_flags |-> (status_next_o[ZF_BIT] == (result_o == '0)));

  p_sign_flag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_flags |-> (status_next_o[SF_BIT] == result_o[MSB]));

  p_reserved_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((status_o & ~FLAG_MASK) == '0));

  p_cmp_no_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_sel_i == 2'b10) |-> !wr_en_o);

  p_status_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !upd_flags |-> (status_next_o == status_o));

  p_reset_clear_r9: assert property (@(posedge clk_i)
    rst_i |=> (status_o == '0));

  p_next_loaded_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (status_o == $past(status_next_o)));
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .op_sel_i      (op_sel_i),
  .upd_flags     (upd_flags),
  .a_i           (a_i),
  .opb           (opb),
  .result_o      (result_o),
  .wr_en_o       (wr_en_o),
  .status_o      (status_o),
  .status_next_o (status_next_o)
);

// File: tb/alu_flags_unit_tb.sv
`timescale 1ns/1ps
module alu_flags_unit_tb_top;

  logic        clk;
  logic        rst;
  logic [1:0]  op_sel;
  logic        imm_sel;
  logic        flag_en;
  logic [31:0] a, b;
  logic [7:0]  imm8;
  logic [31:0] result, status, status_next;
  logic        wr_en;

  int n_chk = 0;
  int n_bad = 0;

  alu_flags_unit dut_i (
    .clk_i(clk), .rst_i(rst), .op_sel_i(op_sel), .imm_sel_i(imm_sel),
    .flag_en_i(flag_en), .a_i(a), .b_i(b), .imm8_i(imm8),
    .result_o(result), .wr_en_o(wr_en), .status_o(status),
    .status_next_o(status_next)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // flags nibble order {OF, SF, ZF, CF}; bit places per R6: 11, 7, 6, 0
  function automatic logic [31:0] mk_status(input logic [3:0] f);
    logic [31:0] w;
    w = 32'h0;
    w[11] = f[3];
    w[7]  = f[2];
    w[6]  = f[1];
    w[0]  = f[0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        imm;
    logic        fen;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  imm8;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
  } vec_t;

  // op: 0 add, 1 sub, 2 cmp, 3 pass (R1); fl = {OF,SF,ZF,CF} after the edge
  localparam vec_t VT [14] = '{
    '{2'd0, 1'b0, 1'b1, 32'd4,        32'd1,        8'h00, 32'd5,        1'b1, 4'b0000},
    '{2'd1, 1'b0, 1'b1, 32'd4,        32'd6,        8'h00, 32'hFFFFFFFE, 1'b1, 4'b0101}, // R3 borrow
    '{2'd0, 1'b1, 1'b1, 32'd4,        32'h0BAD0BAD, 8'hF8, 32'hFFFFFFFC, 1'b1, 4'b0100}, // R2 imm
    '{2'd0, 1'b0, 1'b1, 32'h7FFFFFFF, 32'd1,        8'h00, 32'h80000000, 1'b1, 4'b1100}, // R4
    '{2'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'd1,        8'h00, 32'h00000000, 1'b1, 4'b0011}, // R3 R5
    '{2'd1, 1'b0, 1'b1, 32'h80000000, 32'd1,        8'h00, 32'h7FFFFFFF, 1'b1, 4'b1000}, // R4
    '{2'd2, 1'b0, 1'b1, 32'd6,        32'd6,        8'h00, 32'h00000000, 1'b0, 4'b0010}, // R7
    '{2'd2, 1'b0, 1'b1, 32'd4,        32'd6,        8'h00, 32'hFFFFFFFE, 1'b0, 4'b0101}, // R7
    '{2'd0, 1'b1, 1'b1, 32'd10,       32'hFFFFFFFF, 8'h05, 32'd15,         1'b1, 4'b0000}, // R2
    '{2'd1, 1'b0, 1'b1, 32'h00000000, 32'h80000000, 8'h00, 32'h80000000, 1'b1, 4'b1101}, // R4
    '{2'd0, 1'b0, 1'b1, 32'h80000000, 32'h80000000, 8'h00, 32'h00000000, 1'b1, 4'b1011},
    '{2'd3, 1'b0, 1'b0, 32'h55555555, 32'h12345678, 8'h00, 32'h12345678, 1'b1, 4'b1011}, // R8 hold
    '{2'd1, 1'b1, 1'b1, 32'h00000000, 32'h0BAD0BAD, 8'h80, 32'h00000080, 1'b1, 4'b0001}, // R2
    '{2'd3, 1'b1, 1'b0, 32'h00000000, 32'h00000000, 8'hFF, 32'hFFFFFFFF, 1'b1, 4'b0001}
  };

  // drive at negedge, check combinational outputs, then registered status
  task automatic run_vec(input vec_t v);
    op_sel = v.op; imm_sel = v.imm; flag_en = v.fen;
    a = v.a; b = v.b; imm8 = v.imm8;
    #1;
    chk("R1 result", result, v.res);
    chk("R7 wr_en", {31'b0, wr_en}, {31'b0, v.wr});
    chk("R10 status_next", status_next, mk_status(v.fl));
    @(posedge clk); @(negedge clk);
    chk("R3 R4 R5 R6 R8 status", status, mk_status(v.fl));
  endtask

  initial begin
    rst = 1'b1; op_sel = 2'd3; imm_sel = 1'b0; flag_en = 1'b0;
    a = '0; b = '0; imm8 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset status", status, 32'h0);

    foreach (VT[i]) run_vec(VT[i]);

    // R8: subtract with flag enable low computes but does not load
    run_vec('{2'd1, 1'b0, 1'b0, 32'd4, 32'd6, 8'h00, 32'hFFFFFFFE, 1'b1, 4'b0001});
    // R8: pass-through with flag enable high still holds
    run_vec('{2'd3, 1'b0, 1'b1, 32'd0, 32'd0, 8'h00, 32'h00000000, 1'b1, 4'b0001});
    // R2: sign extension of 0x80 and 0x7F, b_i ignored
    run_vec('{2'd3, 1'b1, 1'b0, 32'd0, 32'h0000FFFF, 8'h80, 32'hFFFFFF80, 1'b1, 4'b0001});
    run_vec('{2'd3, 1'b1, 1'b0, 32'd0, 32'hFFFF0000, 8'h7F, 32'h0000007F, 1'b1, 4'b0001});
    // R9: load flags, then synchronous reset mid-run clears them
    run_vec('{2'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'd1, 8'h00, 32'h0, 1'b1, 4'b0011});
    rst = 1'b1; flag_en = 1'b1; op_sel = 2'd0;
    @(posedge clk); @(negedge clk);
    chk("R9 mid-run reset", status, 32'h0);
    rst = 1'b0; flag_en = 1'b0;
    @(negedge clk);
    chk("R9 held after reset", status, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule